// File: doc/BRIEF.md
# Decode-Stage Register Dependency Interlock

This block sits beside the decode stage of a five-stage in-order pipeline that has no operand forwarding. Each cycle it compares the source register numbers of the instruction being decoded with the destination register numbers of the three instructions further down the pipe: the one about to execute, the one in the memory stage and the one in write-back. If a source still waits on an older, unfinished write, the block holds the fetch address, holds the decode register, and sends an empty slot into execute instead of the decoding instruction.

A downstream stage only counts as a producer when it holds a real instruction whose register-write enable is set. Register 0 is hard-wired and never causes a wait. The hold repeats every cycle until no older writer of that register remains in the pipe, so a consumer right behind its producer waits three cycles.

The block has no state. All three outputs are combinational functions of the current pipeline-register contents, which the surrounding pipeline feeds in directly.

Top module: `hz_interlock`

## Requirements
- R1: A hazard is raised when the decode instruction is valid and either of its two source numbers is non-zero and equal to the destination number of any downstream stage that counts as a writer. Stage index 0 is the execute-entry register, 1 is the memory-stage register and 2 is the write-back register.
- R2: A source number of 0 never raises a hazard, even when a writing stage targets register 0.
- R3: A downstream stage counts as a writer only when both its valid bit and its write-enable bit are 1. Otherwise its destination is ignored.
- R4: When the decode valid bit is 0, no hold or bubble is produced.
- R5: `pc_hold` is 1 exactly when a hazard is present.
- R6: `ifid_hold` is 1 exactly when a hazard is present.
- R7: `bubble` is 1 exactly when a hazard is present. The pipeline then loads an invalid, non-writing slot into execute.
- R8: The outputs follow their inputs in the same cycle, with no register on the path.
- R9: In a pipeline driven by these controls, a consumer that is d instructions after its producer (d = 1 means adjacent) stalls for max(0, 4 − d) cycles. Each stall cycle inserts exactly one bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_valid | input | 1 | Decode register holds a real instruction |
| id_src | input | NUM_SRC*REG_W | Source register numbers of the decode instruction; source k sits at bits [k*REG_W +: REG_W] |
| dst_valid | input | NUM_DST | Valid bit of each downstream stage (0 = execute entry, 1 = memory, 2 = write-back) |
| dst_wen | input | NUM_DST | Register-write enable of each downstream stage |
| dst_rd | input | NUM_DST*REG_W | Destination register number of each downstream stage; stage j at bits [j*REG_W +: REG_W] |
| pc_hold | output | 1 | Keep the fetch address unchanged this cycle |
| ifid_hold | output | 1 | Keep the decode register unchanged this cycle |
| bubble | output | 1 | Load an empty, non-writing slot into execute |

## Verification
The bench uses the default parameters: 5-bit register numbers, two sources and three downstream stages. With these, the directed pipeline runs cover the full stall ladder from three cycles down to none as the gap between producer and consumer grows. Random vectors draw register numbers from a small range, including 0. That makes matches against every stage frequent, along with the r0 and write-disabled cases, and each vector is checked against a reference function in the bench.

// File: rtl/hz_pkg.sv
// Package: shared constants and helpers for the dependency interlock.
// Assumes register number 0 is a hard-wired zero register.
package hz_pkg;

    // Default width of a register number.
    localparam int SPEC_W = 5;

    // Default count of source operands read in decode.
    localparam int SRC_CNT = 2;

    // Default count of downstream stages that may still hold a pending write.
    localparam int DST_CNT = 3;

    // Helper: a stage holds a pending register write.
    function automatic logic live_writer(input logic valid, input logic wen);
        return valid & wen;
    endfunction

endpackage

// File: rtl/hz_cmp.sv
// Module: compares one source register number against one stage destination.
// Assumes: 'live' already folds the stage's valid and write-enable bits.
// A source equal to zero never matches.
module hz_cmp #(
    parameter int REG_W = hz_pkg::SPEC_W
) (
    input  logic             live,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] rd,
    output logic             match
);

    logic src_nonzero;
    logic same_reg;

    // Decide whether this one source waits on this one stage.
    always_comb begin
        src_nonzero = |src;
        same_reg    = (src == rd);
        match       = live & src_nonzero & same_reg;
    end

endmodule

// File: rtl/hz_src_scan.sv
// Module: scans one source register number against every downstream stage.
// Assumes: destinations are packed with stage j at bits [j*REG_W +: REG_W].
module hz_src_scan #(
    parameter int REG_W   = hz_pkg::SPEC_W,
    parameter int NUM_DST = hz_pkg::DST_CNT
) (
    input  logic [REG_W-1:0]         src,
    input  logic [NUM_DST-1:0]       dst_live,
    input  logic [NUM_DST*REG_W-1:0] dst_rd,
    output logic                     hit
);

    logic [NUM_DST-1:0] stage_match;

    for (genvar j = 0; j < NUM_DST; j++) begin : g_stage
        hz_cmp #(.REG_W(REG_W)) u_cmp (
            .live  (dst_live[j]),
            .src   (src),
            .rd    (dst_rd[j*REG_W +: REG_W]),
            .match (stage_match[j])
        );
    end

    // Any stage match makes this source unsafe to read.
    always_comb begin
        hit = |stage_match;
    end

endmodule

// File: rtl/hz_hold_ctrl.sv
// Module: turns per-source hit flags into the three pipeline controls.
// Assumes: the controls are only meaningful while decode holds a real instruction.
module hz_hold_ctrl #(
    parameter int NUM_SRC = hz_pkg::SRC_CNT
) (
    input  logic               id_valid,
    input  logic [NUM_SRC-1:0] src_hit,
    output logic               pc_hold,
    output logic               ifid_hold,
    output logic               bubble
);

    logic stall;

    // Combine the source hits into one stall decision.
    always_comb begin
        stall = id_valid & (|src_hit);
    end

    // Fan the stall decision out to fetch, decode and execute entry.
    always_comb begin
        pc_hold   = stall;
        ifid_hold = stall;
        bubble    = stall;
    end

endmodule

// File: rtl/hz_interlock.sv
// Module: decode-stage stall-only dependency interlock (top).
// Compares every decode source with every downstream destination and raises
// hold/bubble controls while an older write is still pending.
// Assumes: no forwarding exists; the register file is read in decode.
// Stage order: 0 = execute entry, 1 = memory, 2 = write-back. Purely combinational.
module hz_interlock #(
    parameter int REG_W   = hz_pkg::SPEC_W,
    parameter int NUM_SRC = hz_pkg::SRC_CNT,
    parameter int NUM_DST = hz_pkg::DST_CNT
) (
    input  logic                     id_valid,
    input  logic [NUM_SRC*REG_W-1:0] id_src,
    input  logic [NUM_DST-1:0]       dst_valid,
    input  logic [NUM_DST-1:0]       dst_wen,
    input  logic [NUM_DST*REG_W-1:0] dst_rd,
    output logic                     pc_hold,
    output logic                     ifid_hold,
    output logic                     bubble
);

    logic [NUM_DST-1:0] dst_live;
    logic [NUM_SRC-1:0] src_hit;

    // Mark which downstream stages hold a pending register write.
    for (genvar j = 0; j < NUM_DST; j++) begin : g_live
        always_comb begin
            dst_live[j] = hz_pkg::live_writer(dst_valid[j], dst_wen[j]);
        end
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        hz_src_scan #(.REG_W(REG_W), .NUM_DST(NUM_DST)) u_scan (
            .src      (id_src[k*REG_W +: REG_W]),
            .dst_live (dst_live),
            .dst_rd   (dst_rd),
            .hit      (src_hit[k])
        );
    end

    hz_hold_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
        .id_valid  (id_valid),
        .src_hit   (src_hit),
        .pc_hold   (pc_hold),
        .ifid_hold (ifid_hold),
        .bubble    (bubble)
    );

endmodule

// File: rtl/hz_interlock_chk.sv
// Checker: immediate assertions relating the interlock inputs to its outputs.
// Assumes the block is combinational, so every check is evaluated on settled values.
module hz_interlock_chk #(
    parameter int REG_W   = hz_pkg::SPEC_W,
    parameter int NUM_SRC = hz_pkg::SRC_CNT,
    parameter int NUM_DST = hz_pkg::DST_CNT
) (
    input logic                     id_valid,
    input logic [NUM_SRC*REG_W-1:0] id_src,
    input logic [NUM_DST-1:0]       dst_valid,
    input logic [NUM_DST-1:0]       dst_wen,
    input logic [NUM_DST*REG_W-1:0] dst_rd,
    input logic                     pc_hold,
    input logic                     ifid_hold,
    input logic                     bubble
);

    // Check the input/output relations on every change.
    always_comb begin
        // R4: an empty decode slot never holds fetch.
        p_idle_decode_r4: assert (id_valid || !pc_hold);
        // R3: with no live writer downstream, no bubble is injected.
        p_no_writer_r3: assert ((|(dst_valid & dst_wen)) || !bubble);
        // R2: all-zero sources never hold decode.
        p_zero_src_r2: assert ((|id_src) || !ifid_hold);
        // R1: source 0 matching a live write-back stage must hold fetch.
        p_wb_match_r1: assert (!(id_valid && dst_valid[NUM_DST-1] && dst_wen[NUM_DST-1]
                                 && (id_src[REG_W-1:0] != '0)
                                 && (id_src[REG_W-1:0] == dst_rd[(NUM_DST-1)*REG_W +: REG_W]))
                               || pc_hold);
        // R7: a bubble is only injected while decode is frozen.
        p_bubble_hold_r7: assert (!bubble || ifid_hold);
    end

endmodule

bind hz_interlock hz_interlock_chk #(
    .REG_W(REG_W), .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST)
) u_chk (
    .id_valid  (id_valid),
    .id_src    (id_src),
    .dst_valid (dst_valid),
    .dst_wen   (dst_wen),
    .dst_rd    (dst_rd),
    .pc_hold   (pc_hold),
    .ifid_hold (ifid_hold),
    .bubble    (bubble)
);

// File: tb/tb_hz_interlock.sv
// Bench: directed pipeline runs plus seeded random vectors for hz_interlock.
module tb_hz_interlock;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W   = 5;
    localparam int NUM_SRC = 2;
    localparam int NUM_DST = 3;

    typedef struct packed {
        logic             valid;
        logic             wen;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] s0;
        logic [REG_W-1:0] s1;
    } ins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic                     id_valid;
    logic [NUM_SRC*REG_W-1:0] id_src;
    logic [NUM_DST-1:0]       dst_valid;
    logic [NUM_DST-1:0]       dst_wen;
    logic [NUM_DST*REG_W-1:0] dst_rd;
    logic pc_hold, ifid_hold, bubble;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hz_interlock #(.REG_W(REG_W), .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST)) dut (
        .id_valid(id_valid), .id_src(id_src), .dst_valid(dst_valid),
        .dst_wen(dst_wen), .dst_rd(dst_rd),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .bubble(bubble)
    );

    // Reference hazard from the requirement text.
    function automatic logic ref_hazard();
        logic h = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            for (int j = 0; j < NUM_DST; j++) begin
                if (id_valid && dst_valid[j] && dst_wen[j]
                    && id_src[k*REG_W +: REG_W] != '0
                    && id_src[k*REG_W +: REG_W] == dst_rd[j*REG_W +: REG_W])
                    h = 1'b1;
            end
        end
        return h;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        id_valid = 0; id_src = '0; dst_valid = '0; dst_wen = '0; dst_rd = '0;
    endtask

    // Run producer, (gap-1) fillers, consumer through a modelled pipe; count stalls.
    task automatic run_seq(input string req, input ins_t prod, input int gap,
                           input ins_t cons, input int exp_stalls);
        ins_t prog [8];
        ins_t ifid, ex, mem, wb, empty;
        int n, pc, st_pc, st_if, st_bb;
        empty = '0;
        for (int i = 0; i < 8; i++) prog[i] = '0;
        prog[0] = prod;
        for (int i = 1; i < gap; i++) prog[i] = '{valid:1'b1, wen:1'b0, rd:'0, s0:'0, s1:'0};
        prog[gap] = cons;
        n = gap + 1;
        ifid = empty; ex = empty; mem = empty; wb = empty;
        pc = 0; st_pc = 0; st_if = 0; st_bb = 0;
        for (int cyc = 0; cyc < 16; cyc++) begin
            @(negedge clk);
            id_valid = ifid.valid;
            id_src   = {ifid.s1, ifid.s0};
            dst_valid = {wb.valid, mem.valid, ex.valid};
            dst_wen   = {wb.wen, mem.wen, ex.wen};
            dst_rd    = {wb.rd, mem.rd, ex.rd};
            #1;
            if (pc_hold) st_pc++;
            if (ifid_hold) st_if++;
            if (bubble) st_bb++;
            wb  = mem;
            mem = ex;
            ex  = bubble ? empty : ifid;
            if (!ifid_hold) ifid = (pc < n) ? prog[pc] : empty;
            if (!pc_hold && pc < n) pc++;
        end
        check({req, " pc_hold stall cycles"}, st_pc, exp_stalls);
        check({req, " ifid_hold stall cycles"}, st_if, exp_stalls);
        check({req, " bubbles inserted"}, st_bb, exp_stalls);
        drive_idle();
    endtask

    initial begin
        ins_t p, c;
        void'($urandom(32'd20240611));
        drive_idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Idle state: nothing valid, no controls.
        check("R4 idle pc_hold", pc_hold, 0);
        check("R7 idle bubble", bubble, 0);

        p = '{valid:1, wen:1, rd:5'd3, s0:5'd1, s1:5'd2};
        c = '{valid:1, wen:1, rd:5'd5, s0:5'd3, s1:5'd4};
        run_seq("R9 adjacent d=1", p, 1, c, 3);
        run_seq("R9 d=2", p, 2, c, 2);
        run_seq("R9 d=3", p, 3, c, 1);
        run_seq("R9 d=4", p, 4, c, 0);
        c = '{valid:1, wen:1, rd:5'd5, s0:5'd4, s1:5'd3};
        run_seq("R1 second source", p, 1, c, 3);
        p = '{valid:1, wen:1, rd:5'd0, s0:5'd1, s1:5'd2};
        c = '{valid:1, wen:1, rd:5'd6, s0:5'd0, s1:5'd0};
        run_seq("R2 r0 source", p, 1, c, 0);
        p = '{valid:1, wen:0, rd:5'd3, s0:5'd1, s1:5'd2};
        c = '{valid:1, wen:1, rd:5'd6, s0:5'd3, s1:5'd3};
        run_seq("R3 non-writing producer", p, 1, c, 0);

        // R3: valid=0 stage with wen=1 and matching rd is ignored.
        @(negedge clk);
        id_valid = 1; id_src = {5'd0, 5'd7};
        dst_valid = 3'b000; dst_wen = 3'b111; dst_rd = {5'd7, 5'd7, 5'd7};
        #1;
        check("R3 invalid stages ignored", pc_hold, 0);
        // R8: same-cycle response once the memory stage becomes valid.
        dst_valid = 3'b010;
        #1;
        check("R8 same-cycle response", bubble, 1);
        check("R1 memory stage match", ifid_hold, 1);
        // R4: decode slot cleared drops every control.
        id_valid = 0;
        #1;
        check("R4 empty decode", pc_hold | ifid_hold | bubble, 0);

        // Random vectors against the reference function.
        for (int i = 0; i < 3000; i++) begin
            logic e;
            @(negedge clk);
            id_valid = ($urandom_range(0, 7) != 0);
            for (int k = 0; k < NUM_SRC; k++) id_src[k*REG_W +: REG_W] = REG_W'($urandom_range(0, 3));
            for (int j = 0; j < NUM_DST; j++) begin
                dst_valid[j] = $urandom_range(0, 3) != 0;
                dst_wen[j]   = $urandom_range(0, 3) != 0;
                dst_rd[j*REG_W +: REG_W] = REG_W'($urandom_range(0, 3));
            end
            #1;
            e = ref_hazard();
            check("R5 random pc_hold", pc_hold, e);
            check("R6 random ifid_hold", ifid_hold, e);
            check("R7 random bubble", bubble, e);
        end

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule